// File: doc/BRIEF.md
# Sum-of-Products Logic Cell with Bypass and Control Terms

The block is a configurable sum-of-products cell. Twenty-four inputs feed one programmable AND array whose product terms are shared by two OR/XOR groups. Each group of four outputs draws on its own pool of twenty terms. Every output picks one of three data paths: a wide OR of any subset of its pool followed by a polarity XOR, a single selected term followed by the same XOR, or a fast four-term OR with no XOR. Each output is then presented either combinatorially or from a register.

Three further product terms act as controls. The first can clear the output registers, the second can clock them in place of one of three global clock strobes, and the third can drive an output-enable flag for the pads. All global clocks are modelled as single-cycle strobes qualified against the one system clock, so the block stays in a single clock domain.

The configuration is a single serial chain. It shifts only while the synchronous active-low reset is held. Once reset is released, the configuration is frozen.

Top module: `pt_logic_blk`

## Requirements
- R1: A product term is the AND of its selected literals. Term t includes input i in true form when configuration bit 48t+2i is set, and in complemented form when bit 48t+2i+1 is set. A term with no literal selected is 0, and a term selecting both forms of one input is always 0.
- R2: Outputs 0 to 3 use terms 0 to 19 and outputs 4 to 7 use terms 20 to 39. Each output o has a 29-bit field at base 2064+29o, holding mask [19:0], path [21:20], select [26:22], polarity 27 and registered 28. Path 0 (and path 3) gives the OR of the masked pool terms XOR polarity.
- R3: Path 1 gives the pool term numbered by select, XOR polarity. A select value above 19 yields 0 before the XOR.
- R4: Path 2 gives the OR of pool terms 4k to 4k+3, where k is the output's position (0 to 3) within its group. Polarity is ignored on this path.
- R5: With its registered bit clear, an output follows its path value in the same cycle. With the bit set, the output shows the register.
- R6: Global field bits 2296 and 2297 choose the register clock. Values 0, 1 and 2 pick global strobe 0, 1 or 2, and a register loads its path value at a clock edge where the chosen strobe is high. With no strobe and no clear, the register holds.
- R7: Clock choice 3 loads the registers at the edge after term 41 goes from 0 to 1, that is, at the first edge where term 41 is 1 after an edge where it was 0.
- R8: When bit 2298 is set and term 40 is 1 at an edge, all registers clear, even if a clock is present at the same edge.
- R9: The enable output equals term 42 when bit 2299 is set, and is 1 otherwise.
- R10: An edge with reset low clears all registers and the term-41 edge history.
- R11: Configuration bits shift in only while reset is low and shift enable is high. Each new bit enters at the top of the 2300-bit chain, so the bit sent first lands at bit 0. With reset high, shift inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also gates configuration load |
| gclk_tick | input | 3 | Global clock strobes, one per global clock |
| din | input | 24 | Logic inputs from the routing fabric |
| cfg_shift_en | input | 1 | Shift the configuration chain this cycle (reset only) |
| cfg_bit | input | 1 | Serial configuration data |
| dout | output | 8 | Logic outputs |
| oe | output | 1 | Product-term output enable for the pads |

## Verification
Two register events can land on the same edge: a control-term clear and a load, where the load comes from a global strobe or from a rising clock term. The bench drives both control terms from single-literal terms on random inputs and fires the strobes about half the time, so clear and load coincide often. A behavioural model applies the clear first, and its outputs are compared with the block's outputs on every cycle. Garbage is also shifted into the configuration port while the block runs; any change in the outputs would then show up as a mismatch.

// File: rtl/pt_pkg.sv
// Package: shared dimensions and configuration layout of the product-term cell.
// Assumes four outputs per group, and that the bypass needs at most HALF_PT terms.
package pt_pkg;
    localparam int N_IN         = 24;
    localparam int N_HALF       = 2;
    localparam int HALF_PT      = 20;
    localparam int OUT_PER_HALF = 4;
    localparam int BYP_PT       = 4;
    localparam int N_CTRL       = 3;
    localparam int N_OUT        = N_HALF * OUT_PER_HALF;
    localparam int N_PT         = N_HALF * HALF_PT + N_CTRL;
    localparam int SEL_W        = $clog2(HALF_PT) + ((HALF_PT & (HALF_PT - 1)) == 0 ? 1 : 0);
    localparam int AND_W        = N_PT * 2 * N_IN;
    localparam int PATH_W       = 2;
    localparam int CELL_W       = HALF_PT + PATH_W + SEL_W + 1;
    localparam int OCFG_W       = CELL_W + 1;
    localparam int GLB_W        = 4;
    localparam int CFG_W        = AND_W + N_OUT * OCFG_W + GLB_W;
    localparam int GLB_BASE     = AND_W + N_OUT * OCFG_W;
    localparam int PT_CLR       = N_HALF * HALF_PT;
    localparam int PT_CLK       = PT_CLR + 1;
    localparam int PT_OE        = PT_CLR + 2;

    typedef enum logic [PATH_W-1:0] {
        PATH_WIDE   = 2'd0,
        PATH_SINGLE = 2'd1,
        PATH_BYPASS = 2'd2,
        PATH_WIDE2  = 2'd3
    } path_e;
endpackage

// File: rtl/pt_cfg_chain.sv
// Serial configuration chain. Bits enter at the MSB and move toward bit 0.
// Assumes the owner holds reset low for the whole load; the chain is frozen otherwise.
module pt_cfg_chain #(
    parameter int CFG_W = pt_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_bit,
    output logic [CFG_W-1:0] cfg_q
);
    logic [CFG_W-1:0] chain_q;

    // Shift one bit in, only while reset holds the block.
    always_ff @(posedge clk) begin
        if (!rst_n && shift_en) begin
            chain_q <= {shift_bit, chain_q[CFG_W-1:1]};
        end
    end

    assign cfg_q = chain_q;
endmodule

// File: rtl/pt_and_array.sv
// Programmable AND array. Each term takes every input in true form, complemented form or not at all.
// Assumes two configuration bits per input per term, with the true-form bit at the lower position.
module pt_and_array #(
    parameter int N_IN = pt_pkg::N_IN,
    parameter int N_PT = pt_pkg::N_PT
) (
    input  logic [N_IN-1:0]        din,
    input  logic [N_PT*2*N_IN-1:0] lits,
    output logic [N_PT-1:0]        terms
);
    localparam int TERM_W = 2 * N_IN;

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        logic [N_IN-1:0] use_true;
        logic [N_IN-1:0] use_comp;

        // Split the term's configuration into its true and complement selects.
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                use_true[i] = lits[t*TERM_W + 2*i];
                use_comp[i] = lits[t*TERM_W + 2*i + 1];
            end
        end

        // An empty term reads 0; otherwise every chosen literal must hold.
        assign terms[t] = (|(use_true | use_comp))
                        & (&(~use_true | din))
                        & (&(~use_comp | ~din));
    end
endmodule

// File: rtl/pt_clk_ctrl.sv
// Register clock and clear control. It picks a global strobe or a rising clock term,
// and produces the term-driven clear.
// Assumes the global clocks are single-cycle strobes in the system clock domain.
module pt_clk_ctrl #(
    parameter int N_GCLK = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_GCLK-1:0] gclk_tick,
    input  logic [1:0]        clk_sel,
    input  logic              clk_term,
    input  logic              clr_term,
    input  logic              clr_en,
    output logic              tick,
    output logic              clr
);
    logic clk_term_q;

    // Remember the clock term so its rising edge can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_term_q <= 1'b0;
        end else begin
            clk_term_q <= clk_term;
        end
    end

    // Choose the register load strobe.
    always_comb begin
        if (int'(clk_sel) < N_GCLK) begin
            tick = gclk_tick[clk_sel];
        end else begin
            tick = clk_term & ~clk_term_q;
        end
    end

    assign clr = clr_en & clr_term;
endmodule

// File: rtl/pt_out_cell.sv
// One output slice. It computes the path value (wide OR + XOR, single term + XOR,
// or four-term bypass) and holds its register.
// Assumes the clear has priority over the load, and that the bypass terms lie inside the pool.
module pt_out_cell #(
    parameter int HALF_PT = pt_pkg::HALF_PT,
    parameter int SEL_W   = pt_pkg::SEL_W,
    parameter int BYP_PT  = pt_pkg::BYP_PT,
    parameter int LIDX    = 0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [HALF_PT-1:0]                pool,
    input  logic [HALF_PT+2+SEL_W+1-1:0]      cfg,
    input  logic                              tick,
    input  logic                              clr,
    output logic                              d,
    output logic                              q
);
    import pt_pkg::*;
    localparam int PATH_LO = HALF_PT;
    localparam int SEL_LO  = HALF_PT + 2;
    localparam int POL_BIT = HALF_PT + 2 + SEL_W;

    logic [HALF_PT-1:0] mask;
    path_e              path;
    logic [SEL_W-1:0]   sel;
    logic               pol;
    logic               single_raw;

    assign mask = cfg[HALF_PT-1:0];
    assign path = path_e'(cfg[PATH_LO +: 2]);
    assign sel  = cfg[SEL_LO +: SEL_W];
    assign pol  = cfg[POL_BIT];

    // Pick the single term; out-of-range selects read 0.
    always_comb begin
        single_raw = 1'b0;
        for (int j = 0; j < HALF_PT; j++) begin
            if (sel == SEL_W'(j)) begin
                single_raw = pool[j];
            end
        end
    end

    // Form the path value for the chosen route.
    always_comb begin
        unique case (path)
            PATH_SINGLE: d = single_raw ^ pol;
            PATH_BYPASS: d = |pool[LIDX*BYP_PT +: BYP_PT];
            default:     d = (|(pool & mask)) ^ pol;
        endcase
    end

    // Output register: reset, then term clear, then load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (clr) begin
            q <= 1'b0;
        end else if (tick) begin
            q <= d;
        end
    end
endmodule

// File: rtl/pt_logic_blk.sv
// Top of the sum-of-products cell. It joins the configuration chain, the AND array,
// two output groups and the clock/clear control.
// Assumes the configuration is loaded under reset before the block is used.
module pt_logic_blk #(
    parameter int N_IN         = pt_pkg::N_IN,
    parameter int N_HALF       = pt_pkg::N_HALF,
    parameter int HALF_PT      = pt_pkg::HALF_PT,
    parameter int OUT_PER_HALF = pt_pkg::OUT_PER_HALF,
    parameter int N_GCLK       = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_GCLK-1:0]              gclk_tick,
    input  logic [N_IN-1:0]                din,
    input  logic                           cfg_shift_en,
    input  logic                           cfg_bit,
    output logic [N_HALF*OUT_PER_HALF-1:0] dout,
    output logic                           oe
);
    localparam int N_OUT    = N_HALF * OUT_PER_HALF;
    localparam int N_PT     = N_HALF * HALF_PT + 3;
    localparam int SEL_W    = pt_pkg::SEL_W;
    localparam int CELL_W   = HALF_PT + 2 + SEL_W + 1;
    localparam int OCFG_W   = CELL_W + 1;
    localparam int AND_W    = N_PT * 2 * N_IN;
    localparam int GLB_BASE = AND_W + N_OUT * OCFG_W;
    localparam int CFG_W    = GLB_BASE + 4;
    localparam int T_CLR    = N_HALF * HALF_PT;
    localparam int T_CLK    = T_CLR + 1;
    localparam int T_OE     = T_CLR + 2;

    logic [CFG_W-1:0] cfg_q;
    logic [N_PT-1:0]  terms;
    logic [N_OUT-1:0] d_all;
    logic [N_OUT-1:0] q_all;
    logic [N_OUT-1:0] regd;
    logic [1:0]       clk_sel;
    logic             clr_en;
    logic             oe_en_cfg;
    logic             tick;
    logic             clr;

    assign clk_sel   = cfg_q[GLB_BASE +: 2];
    assign clr_en    = cfg_q[GLB_BASE + 2];
    assign oe_en_cfg = cfg_q[GLB_BASE + 3];

    pt_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .shift_bit(cfg_bit),
        .cfg_q    (cfg_q)
    );

    pt_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .din  (din),
        .lits (cfg_q[AND_W-1:0]),
        .terms(terms)
    );

    pt_clk_ctrl #(.N_GCLK(N_GCLK)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .gclk_tick(gclk_tick),
        .clk_sel  (clk_sel),
        .clk_term (terms[T_CLK]),
        .clr_term (terms[T_CLR]),
        .clr_en   (clr_en),
        .tick     (tick),
        .clr      (clr)
    );

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        for (genvar k = 0; k < OUT_PER_HALF; k++) begin : g_out
            localparam int O     = h * OUT_PER_HALF + k;
            localparam int OBASE = AND_W + O * OCFG_W;

            pt_out_cell #(
                .HALF_PT(HALF_PT),
                .SEL_W  (SEL_W),
                .BYP_PT (pt_pkg::BYP_PT),
                .LIDX   (k)
            ) u_cell (
                .clk  (clk),
                .rst_n(rst_n),
                .pool (terms[h*HALF_PT +: HALF_PT]),
                .cfg  (cfg_q[OBASE +: CELL_W]),
                .tick (tick),
                .clr  (clr),
                .d    (d_all[O]),
                .q    (q_all[O])
            );

            assign regd[O] = cfg_q[OBASE + CELL_W];
        end
    end

    // Present each output combinatorially or from its register.
    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            dout[o] = regd[o] ? q_all[o] : d_all[o];
        end
    end

    assign oe = oe_en_cfg ? terms[T_OE] : 1'b1;
endmodule

// File: rtl/pt_logic_blk_chk.sv
// Checker for the product-term cell: register clear, hold, configuration freeze and enable default.
// Assumes it is bound into pt_logic_blk and sees its internal strobes.
module pt_logic_blk_chk #(
    parameter int N_OUT = 8,
    parameter int CFG_W = 2300
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] q,
    input logic             tick,
    input logic             clr,
    input logic [CFG_W-1:0] cfg,
    input logic             oe,
    input logic             oe_en
);
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> q == '0); // R10
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> $stable(cfg)); // R11
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(clr)) |-> q == '0); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && !$past(tick) && !$past(clr)) |-> $stable(q)); // R6
    AST_OE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n) !oe_en |-> oe); // R9
endmodule

bind pt_logic_blk pt_logic_blk_chk #(.N_OUT(N_OUT), .CFG_W(CFG_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .q    (q_all),
    .tick (tick),
    .clr  (clr),
    .cfg  (cfg_q),
    .oe   (oe),
    .oe_en(oe_en_cfg)
);

// File: tb/pt_logic_blk_bench.sv
module pt_logic_blk_bench;
    import pt_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       gclk_tick = '0;
    logic [N_IN-1:0]  din = '0;
    logic             cfg_shift_en = 1'b0;
    logic             cfg_bit = 1'b0;
    logic [N_OUT-1:0] dout;
    logic             oe;

    int n_chk = 0;
    int n_fail = 0;

    // model configuration
    bit               lt [N_PT][N_IN];
    bit               lc [N_PT][N_IN];
    bit [HALF_PT-1:0] m_mask [N_OUT];
    int               m_path [N_OUT];
    int               m_sel  [N_OUT];
    bit               m_pol  [N_OUT];
    bit               m_regd [N_OUT];
    int               m_clksel;
    bit               m_clren;
    bit               m_oeen;
    // model state
    bit               mq [N_OUT];
    bit               mptc;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_logic_blk u_pt_logic_blk (
        .clk(clk), .rst_n(rst_n), .gclk_tick(gclk_tick), .din(din),
        .cfg_shift_en(cfg_shift_en), .cfg_bit(cfg_bit), .dout(dout), .oe(oe)
    );

    function automatic logic [N_PT-1:0] calc_terms(logic [N_IN-1:0] x);
        logic [N_PT-1:0] r;
        for (int t = 0; t < N_PT; t++) begin
            bit any = 0;
            bit ok = 1;
            for (int i = 0; i < N_IN; i++) begin
                if (lt[t][i]) begin any = 1; if (!x[i]) ok = 0; end
                if (lc[t][i]) begin any = 1; if (x[i]) ok = 0; end
            end
            r[t] = any && ok;
        end
        return r;
    endfunction

    function automatic bit calc_d(int o, logic [N_PT-1:0] t);
        int base = (o / OUT_PER_HALF) * HALF_PT;
        int k = o % OUT_PER_HALF;
        bit v = 0;
        case (m_path[o])
            1: begin
                if (m_sel[o] < HALF_PT) v = t[base + m_sel[o]];
                return v ^ m_pol[o];
            end
            2: begin
                for (int j = 0; j < 4; j++) v |= t[base + 4*k + j];
                return v;
            end
            default: begin
                for (int j = 0; j < HALF_PT; j++) v |= (t[base + j] & m_mask[o][j]);
                return v ^ m_pol[o];
            end
        endcase
    endfunction

    task automatic model_step(logic [N_PT-1:0] t);
        bit tk;
        bit dv [N_OUT];
        for (int o = 0; o < N_OUT; o++) dv[o] = calc_d(o, t);
        if (!rst_n) begin
            for (int o = 0; o < N_OUT; o++) mq[o] = 0;
            mptc = 0;
        end else begin
            tk = (m_clksel < 3) ? gclk_tick[m_clksel] : (t[PT_CLK] && !mptc);
            if (m_clren && t[PT_CLR]) begin
                for (int o = 0; o < N_OUT; o++) mq[o] = 0;
            end else if (tk) begin
                for (int o = 0; o < N_OUT; o++) mq[o] = dv[o];
            end
            mptc = t[PT_CLK];
        end
    endtask

    task automatic cyc(string tag, bit do_chk);
        logic [N_PT-1:0] t;
        logic [N_OUT-1:0] e;
        #1;
        t = calc_terms(din);
        for (int o = 0; o < N_OUT; o++) e[o] = m_regd[o] ? mq[o] : calc_d(o, t);
        if (do_chk) begin
            n_chk++;
            if (dout !== e) begin
                n_fail++;
                $display("FAIL %s dout act=%h exp=%h", tag, dout, e);
            end
            n_chk++;
            if (oe !== (m_oeen ? t[PT_OE] : 1'b1)) begin
                n_fail++;
                $display("FAIL %s oe act=%b exp=%b", tag, oe, m_oeen ? t[PT_OE] : 1'b1);
            end
        end
        @(posedge clk);
        model_step(t);
        @(negedge clk);
    endtask

    task automatic clear_cfg();
        for (int t = 0; t < N_PT; t++)
            for (int i = 0; i < N_IN; i++) begin lt[t][i] = 0; lc[t][i] = 0; end
        for (int o = 0; o < N_OUT; o++) begin
            m_mask[o] = '0; m_path[o] = 0; m_sel[o] = 0; m_pol[o] = 0; m_regd[o] = 0;
        end
        m_clksel = 0; m_clren = 0; m_oeen = 0;
    endtask

    task automatic rand_cfg(int clksel, bit clren, bit oeen);
        clear_cfg();
        for (int t = 0; t < N_PT; t++) begin
            int nl = (t >= PT_CLR) ? 1 : $urandom_range(0, 3);
            for (int n = 0; n < nl; n++) begin
                int i = $urandom_range(0, N_IN-1);
                if ($urandom % 2) lt[t][i] = 1; else lc[t][i] = 1;
            end
        end
        for (int o = 0; o < N_OUT; o++) begin
            m_mask[o] = HALF_PT'($urandom);
            m_path[o] = $urandom_range(0, 3);
            m_sel[o]  = $urandom_range(0, 31);
            m_pol[o]  = $urandom % 2;
            m_regd[o] = $urandom % 2;
        end
        m_clksel = clksel; m_clren = clren; m_oeen = oeen;
    endtask

    // Load the model configuration through the chain under reset (R11: bit 0 sent first).
    task automatic load_cfg(string tag);
        logic [CFG_W-1:0] v;
        v = '0;
        for (int t = 0; t < N_PT; t++)
            for (int i = 0; i < N_IN; i++) begin
                v[t*2*N_IN + 2*i]     = lt[t][i];
                v[t*2*N_IN + 2*i + 1] = lc[t][i];
            end
        for (int o = 0; o < N_OUT; o++) begin
            int b = AND_W + o*OCFG_W;
            v[b +: HALF_PT]           = m_mask[o];
            v[b + HALF_PT +: 2]       = 2'(m_path[o]);
            v[b + HALF_PT + 2 +: SEL_W] = SEL_W'(m_sel[o]);
            v[b + HALF_PT + 2 + SEL_W] = m_pol[o];
            v[b + CELL_W]             = m_regd[o];
        end
        v[GLB_BASE +: 2] = 2'(m_clksel);
        v[GLB_BASE + 2]  = m_clren;
        v[GLB_BASE + 3]  = m_oeen;
        rst_n = 0;
        for (int i = 0; i < CFG_W; i++) begin
            cfg_shift_en = 1; cfg_bit = v[i];
            cyc(tag, 0);
        end
        cfg_shift_en = 0;
        // reset state: registers clear, combinational outputs live (R10)
        for (int i = 0; i < 3; i++) begin
            din = N_IN'($urandom);
            cyc("R10 reset state", 1);
        end
    endtask

    // Run with random inputs, strobes and ignored configuration traffic (R11).
    task automatic run(string tag, int n);
        rst_n = 1;
        for (int c = 0; c < n; c++) begin
            din = N_IN'($urandom);
            gclk_tick = 3'($urandom);
            cfg_shift_en = $urandom % 2;
            cfg_bit = $urandom % 2;
            cyc(tag, 1);
        end
        cfg_shift_en = 0;
        gclk_tick = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 directed: literal forms, empty term, contradictory term
        clear_cfg();
        lt[0][0] = 1; lc[0][1] = 1;
        lt[1][2] = 1; lc[1][2] = 1;
        m_mask[0] = 20'h1;
        m_mask[1] = 20'h2;
        m_mask[2] = 20'h4; m_pol[2] = 1;
        m_path[3] = 1; m_sel[3] = 0; m_pol[3] = 1;
        m_path[4] = 1; m_sel[4] = 25;
        load_cfg("R1");
        run("R1 R3 literal/empty/contradiction", 60);
        // R2 R3 R4 R5 R6 with each global strobe
        for (int s = 0; s < 3; s++) begin
            for (int r = 0; r < 2; r++) begin
                rand_cfg(s, 0, $urandom % 2);
                load_cfg("R6");
                run("R2 R3 R4 R5 R6 R11", 250);
            end
        end
        // R7 term-driven clock
        for (int r = 0; r < 2; r++) begin
            rand_cfg(3, 0, 0);
            load_cfg("R7");
            run("R7 R5", 250);
        end
        // R8 term clear racing loads
        for (int r = 0; r < 4; r++) begin
            rand_cfg(r, 1, 0);
            for (int o = 0; o < N_OUT; o++) m_regd[o] = 1;
            load_cfg("R8");
            run("R8 clear vs load", 250);
        end
        // R9 enable from term
        rand_cfg(0, 0, 1);
        load_cfg("R9");
        run("R9 R11", 200);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule